// File: doc/BRIEF.md
# Quadword Lane Permute Unit

This unit rearranges the lanes of a 128-bit register value. It receives two source operands (called `rs` and `rt`), each with the register index it was read from, a 4-bit operation code and a destination register index. It produces a 128-bit result together with a write enable and the destination index, ready for a register file write port. Every operation is a fixed cross-lane shuffle with a defined lane order. No arithmetic is done.

A source whose index is 0 is treated as all zeros, whatever value arrives on its data port. A destination index of 0, or an operation code outside the defined set, produces no write. The shuffle network is purely combinational. A parameter chooses whether the result leaves through one register stage (the default, one cycle of latency) or goes straight to the outputs.

Top module: `lane_permute`

## Requirements
- R1: Operation code 0 (pack even words) gives result words, lowest first: rt word 0, rt word 2, rs word 0, rs word 2 (word k is bits 32k+31:32k).
- R2: Operation code 1 (interleave low bytes) sets result byte 2i to rt byte i and result byte 2i+1 to rs byte i, for i = 0..7, so the 8 low bytes of each operand fill all 16 result bytes.
- R3: Operation code 2 (interleave low halfwords) sets result halfword 2i to rt halfword i and result halfword 2i+1 to rs halfword i, for i = 0..3.
- R4: Operation code 3 (interleave low words) gives result words, lowest first: rt.w0, rs.w0, rt.w1, rs.w1.
- R5: Operation code 4 (interleave high words) gives result words, lowest first: rt.w2, rs.w2, rt.w3, rs.w3.
- R6: Operation code 5 (replicate halfword) writes rt bits 15:0 into all four halfwords of result bits 63:0 and rt bits 79:64 into all four halfwords of result bits 127:64.
- R7: Operation code 6 (copy low doublewords) sets result bits 63:0 to rt bits 63:0 and result bits 127:64 to rs bits 63:0.
- R8: Operation code 7 (copy high doublewords) sets result bits 63:0 to rs bits 127:64 and result bits 127:64 to rt bits 127:64.
- R9: Operation code 8 (rotate three words) gives result words, lowest first: rt.w1, rt.w2, rt.w0, rt.w3. Word 3 keeps its place.
- R10: A valid operation with destination index 0 leaves the write enable low.
- R11: A source index of 0 makes that operand read as all zeros, whatever its data port carries.
- R12: Operation codes 9 to 15 leave the write enable low.
- R13: With the output register on (default), a valid operation sent in one cycle shows its write enable, index and result after the next rising clock edge. An idle input cycle gives no write. Reset clears the write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| rs_idx | input | IDX_W | Register index the rs operand came from |
| rt_idx | input | IDX_W | Register index the rt operand came from |
| dst_idx | input | IDX_W | Destination register index |
| rs_data | input | DATA_W | rs operand value |
| rt_data | input | DATA_W | rt operand value |
| wr_en | output | 1 | Result write enable |
| wr_idx | output | IDX_W | Destination index of the result |
| wr_data | output | DATA_W | Permuted result |

## Verification
The assertions check on every cycle that no write ever targets index 0 and that unknown codes never enable a write. They also check that the two doubleword-copy operations and the rotate's fixed top word follow the rt operand with zero-index masking, and that the output stage forwards exactly what the network produced one cycle before. The exact lane orders of packing, interleaving at each width and halfword replication are shown only by the bench scenarios. The same holds for back-to-back streams of mixed operations and for zero-index masking on the other operations: the scoreboard compares these against its own lane model.

// File: rtl/lane_permute_pkg.sv
// Package: shared operation codes and sizes of the lane permute unit.
// Assumes 4-bit operation codes. Codes above PERM_LAST are undefined.
package lane_permute_pkg;

    typedef enum logic [3:0] {
        OP_PACK_EVEN_W = 4'd0,
        OP_ILV_LO_B    = 4'd1,
        OP_ILV_LO_H    = 4'd2,
        OP_ILV_LO_W    = 4'd3,
        OP_ILV_HI_W    = 4'd4,
        OP_REP_H       = 4'd5,
        OP_COPY_LO_D   = 4'd6,
        OP_COPY_HI_D   = 4'd7,
        OP_ROT3_W      = 4'd8
    } perm_op_e;

    localparam logic [3:0] PERM_LAST = 4'd8;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

endpackage

// File: rtl/perm_interleave.sv
// Module: interleaves the lanes of two half-width inputs into one full-width value.
// Output lane 2i takes lane i of even_src, and output lane 2i+1 takes lane i of odd_src.
// Assumes LANE_W divides SRC_W.
module perm_interleave #(
    parameter int SRC_W  = 64,
    parameter int LANE_W = 8
) (
    input  logic [SRC_W-1:0]   even_src,
    input  logic [SRC_W-1:0]   odd_src,
    output logic [2*SRC_W-1:0] merged
);
    localparam int LANES = SRC_W / LANE_W;

    // One pair of output lanes per input lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[(2*i)*LANE_W   +: LANE_W] = even_src[i*LANE_W +: LANE_W];
        assign merged[(2*i+1)*LANE_W +: LANE_W] = odd_src[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/perm_fixed.sv
// Module: shuffles that are not interleaves (pack, replicate, copy, rotate).
// All are word-, halfword- or doubleword-granular selections from a and b.
// Assumes DATA_W is 128 (four words, two doublewords).
module perm_fixed
    import lane_permute_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] pack_r,
    output logic [DATA_W-1:0] rep_r,
    output logic [DATA_W-1:0] cplo_r,
    output logic [DATA_W-1:0] cphi_r,
    output logic [DATA_W-1:0] rot_r
);
    localparam int DW_W  = DATA_W / 2;
    localparam int NWORD = DATA_W / WORD_W;
    localparam int NREP  = DW_W / HALF_W;

    logic [WORD_W-1:0] aw [NWORD];
    logic [WORD_W-1:0] bw [NWORD];

    // Split both operands into words.
    for (genvar k = 0; k < NWORD; k++) begin : g_split
        assign aw[k] = a_val[k*WORD_W +: WORD_W];
        assign bw[k] = b_val[k*WORD_W +: WORD_W];
    end

    // Even words of b then even words of a.
    assign pack_r = {aw[2], aw[0], bw[2], bw[0]};

    // Lowest halfword of each doubleword of b, repeated across that doubleword.
    assign rep_r = {{NREP{b_val[DW_W +: HALF_W]}}, {NREP{b_val[0 +: HALF_W]}}};

    // Low doublewords: b low stays low, a low moves high.
    assign cplo_r = {a_val[0 +: DW_W], b_val[0 +: DW_W]};

    // High doublewords: a high moves low, b high stays high.
    assign cphi_r = {b_val[DW_W +: DW_W], a_val[DW_W +: DW_W]};

    // Rotate words 0..2 of b down by one, word 3 fixed.
    assign rot_r = {bw[3], bw[0], bw[2], bw[1]};

endmodule

// File: rtl/perm_core.sv
// Module: the complete combinational shuffle network with operation select.
// Flags whether the operation code is defined. Undefined codes give a zero result.
module perm_core
    import lane_permute_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] rs_v,
    input  logic [DATA_W-1:0] rt_v,
    output logic [DATA_W-1:0] res,
    output logic              known
);
    localparam int DW_W = DATA_W / 2;
    localparam int NILV = 4;

    logic [DATA_W-1:0] ilv [NILV];
    logic [DATA_W-1:0] pack_r, rep_r, cplo_r, cphi_r, rot_r;

    // Low-half interleaves at byte, halfword and word width; then the high-half word interleave.
    for (genvar k = 0; k < NILV; k++) begin : g_ilv
        localparam int LW  = (k < 3) ? (8 << k) : WORD_W;
        localparam int OFS = (k < 3) ? 0 : DW_W;
        perm_interleave #(.SRC_W(DW_W), .LANE_W(LW)) u_ilv (
            .even_src (rt_v[OFS +: DW_W]),
            .odd_src  (rs_v[OFS +: DW_W]),
            .merged   (ilv[k])
        );
    end

    perm_fixed #(.DATA_W(DATA_W)) u_fixed (
        .a_val  (rs_v),
        .b_val  (rt_v),
        .pack_r (pack_r),
        .rep_r  (rep_r),
        .cplo_r (cplo_r),
        .cphi_r (cphi_r),
        .rot_r  (rot_r)
    );

    // Pick the shuffle named by the operation code.
    always_comb begin
        known = 1'b1;
        case (op)
            OP_PACK_EVEN_W: res = pack_r;
            OP_ILV_LO_B:    res = ilv[0];
            OP_ILV_LO_H:    res = ilv[1];
            OP_ILV_LO_W:    res = ilv[2];
            OP_ILV_HI_W:    res = ilv[3];
            OP_REP_H:       res = rep_r;
            OP_COPY_LO_D:   res = cplo_r;
            OP_COPY_HI_D:   res = cphi_r;
            OP_ROT3_W:      res = rot_r;
            default: begin
                res   = '0;
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_permute.sv
// Module: top of the lane permute unit.
// Masks sources read from index 0 and suppresses writes to index 0 and for unknown codes.
// Registers the result when OUT_REG is 1. Synchronous active-low reset.
module lane_permute #(
    parameter int DATA_W  = 128,
    parameter int IDX_W   = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [IDX_W-1:0]  rs_idx,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] rs_data,
    input  logic [DATA_W-1:0] rt_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] opa, opb, res_c;
    logic              op_known, we_c;
    logic [IDX_W-1:0]  idx_c;

    // Index 0 reads as all zeros.
    assign opa = (rs_idx == '0) ? '0 : rs_data;
    assign opb = (rt_idx == '0) ? '0 : rt_data;

    perm_core #(.DATA_W(DATA_W)) u_core (
        .op    (op),
        .rs_v  (opa),
        .rt_v  (opb),
        .res   (res_c),
        .known (op_known)
    );

    // Write only for a valid, defined operation aimed at a nonzero index.
    assign we_c  = in_valid && op_known && (dst_idx != '0);
    assign idx_c = dst_idx;

    if (OUT_REG) begin : g_reg
        // Output stage: one cycle of latency, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_en   <= 1'b0;
                wr_idx  <= '0;
                wr_data <= '0;
            end else begin
                wr_en   <= we_c;
                wr_idx  <= idx_c;
                wr_data <= res_c;
            end
        end
    end else begin : g_comb
        assign wr_en   = we_c;
        assign wr_idx  = idx_c;
        assign wr_data = res_c;
    end

endmodule

// File: rtl/lane_permute_chk.sv
// Module: checker bound to lane_permute.
// Watches the ports plus the combinational result and write enable ahead of the output stage.
module lane_permute_chk #(
    parameter int DATA_W  = 128,
    parameter int IDX_W   = 5,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic [IDX_W-1:0]  rs_idx,
    input logic [IDX_W-1:0]  rt_idx,
    input logic [DATA_W-1:0] rt_data,
    input logic              we_c,
    input logic [IDX_W-1:0]  idx_c,
    input logic [DATA_W-1:0] res_c,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data
);
    localparam int DW_W = DATA_W / 2;

    logic [DATA_W-1:0] rt_m;
    assign rt_m = (rt_idx == '0) ? '0 : rt_data;

    // R10: no write ever reaches index 0, inside the network or at the port.
    assert_no_zero_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_c |-> idx_c != '0) and (wr_en |-> wr_idx != '0));

    // R12: undefined codes never enable a write.
    assert_unknown_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd8) |-> !we_c);

    // R7: copy-low keeps rt low doubleword in place.
    assert_copy_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6) |-> res_c[DW_W-1:0] == rt_m[DW_W-1:0]);

    // R8: copy-high keeps rt high doubleword in place.
    assert_copy_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd7) |-> res_c[DATA_W-1:DW_W] == rt_m[DATA_W-1:DW_W]);

    // R9: rotate leaves the top word of rt where it was.
    assert_rot_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd8) |-> res_c[DATA_W-1 -: 32] == rt_m[DATA_W-1 -: 32]);

    // R11: copy-low from rs index 0 gives a zero high doubleword.
    assert_zero_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6 && rs_idx == '0) |-> res_c[DATA_W-1:DW_W] == '0);

    if (OUT_REG) begin : g_reg_chk
        // R13: the output stage forwards last cycle's network output.
        assert_out_stage_R13: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (wr_en == $past(we_c)) && (wr_idx == $past(idx_c))
                             && (!wr_en || wr_data == $past(res_c)));
    end else begin : g_comb_chk
        // R13: without the register the outputs follow the network directly.
        assert_out_stage_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en == we_c) && (wr_idx == idx_c) && (wr_data == res_c));
    end

endmodule

bind lane_permute lane_permute_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .rt_data(rt_data),
    .we_c(we_c), .idx_c(idx_c), .res_c(res_c),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/lane_permute_test.sv
// Scoreboard bench: a driver task queues the expected writes, and a monitor pops and compares them.
module lane_permute_test;
    localparam int DW = 128;
    localparam int IW = 5;

    typedef struct {
        logic          en;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    op = '0;
    logic [IW-1:0] rs_idx = '0, rt_idx = '0, dst_idx = '0;
    logic [DW-1:0] rs_data = '0, rt_data = '0;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #10 clk = ~clk;

    lane_permute #(.DATA_W(DW), .IDX_W(IW), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .dst_idx(dst_idx),
        .rs_data(rs_data), .rt_data(rt_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Lane-level reference model, built byte by byte from the requirements.
    function automatic exp_t model(input logic v, input logic [3:0] o,
                                   input logic [IW-1:0] si, input logic [IW-1:0] ti,
                                   input logic [IW-1:0] di,
                                   input logic [DW-1:0] s, input logic [DW-1:0] t);
        exp_t e;
        logic [7:0] a [16];
        logic [7:0] b [16];
        logic [7:0] r [16];
        int map [16];
        bit fa [16];
        for (int i = 0; i < 16; i++) begin
            a[i] = (si == 0) ? 8'h00 : s[8*i +: 8];
            b[i] = (ti == 0) ? 8'h00 : t[8*i +: 8];
            map[i] = 0;
            fa[i] = 1'b0;
        end
        // map[i] is the source byte of result byte i; fa[i] picks rs (1) or rt (0).
        for (int i = 0; i < 16; i++) begin
            case (o)
                4'd0: begin fa[i] = (i >= 8); map[i] = (i % 4) + ((i % 8) >= 4 ? 8 : 0); end
                4'd1: begin fa[i] = i[0]; map[i] = i / 2; end
                4'd2: begin fa[i] = ((i / 2) % 2) == 1; map[i] = (i / 4) * 2 + (i % 2); end
                4'd3: begin fa[i] = ((i / 4) % 2) == 1; map[i] = (i / 8) * 4 + (i % 4); end
                4'd4: begin fa[i] = ((i / 4) % 2) == 1; map[i] = 8 + (i / 8) * 4 + (i % 4); end
                4'd5: begin fa[i] = 1'b0; map[i] = (i / 8) * 8 + (i % 2); end
                4'd6: begin fa[i] = (i >= 8); map[i] = i % 8; end
                4'd7: begin fa[i] = (i < 8); map[i] = 8 + (i % 8); end
                4'd8: begin
                    fa[i] = 1'b0;
                    case (i / 4)
                        0: map[i] = 4 + i % 4;
                        1: map[i] = 8 + i % 4;
                        2: map[i] = i % 4;
                        default: map[i] = i;
                    endcase
                end
                default: begin fa[i] = 1'b0; map[i] = i; end
            endcase
            r[i] = fa[i] ? a[map[i]] : b[map[i]];
        end
        for (int i = 0; i < 16; i++) e.data[8*i +: 8] = r[i];
        e.en  = v && (o <= 4'd8) && (di != 0);
        e.idx = di;
        e.tag = "";
        return e;
    endfunction

    // Driver: presents one operation at a falling edge and queues its expected write.
    task automatic send(input logic v, input logic [3:0] o, input logic [IW-1:0] si,
                        input logic [IW-1:0] ti, input logic [IW-1:0] di,
                        input logic [DW-1:0] s, input logic [DW-1:0] t, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v; op = o; rs_idx = si; rt_idx = ti; dst_idx = di;
        rs_data = s; rt_data = t;
        e = model(v, o, si, ti, di, s, t);
        e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic [DW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Monitor: compares each registered result shortly after the edge that loads it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (wr_en !== e.en || (e.en && (wr_idx !== e.idx || wr_data !== e.data))) begin
                    n_fail++;
                    $display("FAIL %s: got en=%0b idx=%0d data=%h, expected en=%0b idx=%0d data=%h",
                             e.tag, wr_en, wr_idx, wr_data, e.en, e.idx, e.data);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string names [9];
        logic [DW-1:0] s, t;
        names[0] = "R1 pack";  names[1] = "R2 ilv byte"; names[2] = "R3 ilv half";
        names[3] = "R4 ilv word"; names[4] = "R5 ilv high word"; names[5] = "R6 replicate";
        names[6] = "R7 copy low"; names[7] = "R8 copy high"; names[8] = "R9 rotate";

        // R13: reset state.
        repeat (3) @(negedge clk);
        n_chk++;
        if (wr_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R13 reset: got wr_en=%0b, expected 0", wr_en);
        end
        rst_n = 1'b1;

        // Each operation with a recognisable pattern and with random data.
        s = 128'h1f1e1d1c_1b1a1918_17161514_13121110;
        t = 128'h2f2e2d2c_2b2a2928_27262524_23222120;
        for (int k = 0; k < 9; k++) send(1, 4'(k), 5'd3, 5'd7, 5'd9, s, t, names[k]);
        for (int k = 0; k < 9; k++) send(1, 4'(k), 5'd4, 5'd8, 5'd31, rnd128(), rnd128(), names[k]);

        // R11: zero-index sources on several operations.
        send(1, 4'd6, 5'd0, 5'd2, 5'd5, rnd128(), rnd128(), "R11 rs zero copy low");
        send(1, 4'd8, 5'd1, 5'd0, 5'd5, rnd128(), rnd128(), "R11 rt zero rotate");
        send(1, 4'd1, 5'd0, 5'd6, 5'd5, rnd128(), rnd128(), "R11 rs zero ilv byte");
        send(1, 4'd0, 5'd0, 5'd0, 5'd5, rnd128(), rnd128(), "R11 both zero pack");

        // R10: destination 0 writes nothing.
        send(1, 4'd0, 5'd3, 5'd4, 5'd0, rnd128(), rnd128(), "R10 dst zero");
        send(1, 4'd8, 5'd3, 5'd4, 5'd0, rnd128(), rnd128(), "R10 dst zero rotate");

        // R12: undefined codes.
        send(1, 4'd9, 5'd3, 5'd4, 5'd6, rnd128(), rnd128(), "R12 code 9");
        send(1, 4'd15, 5'd3, 5'd4, 5'd6, rnd128(), rnd128(), "R12 code 15");

        // R13: idle cycle between valid ones.
        send(0, 4'd6, 5'd3, 5'd4, 5'd6, rnd128(), rnd128(), "R13 idle");
        send(1, 4'd7, 5'd3, 5'd4, 5'd6, rnd128(), rnd128(), "R8 after idle");

        // Back-to-back mixed stream.
        for (int k = 0; k < 40; k++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 10));
            send(1, o, 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
                 5'($urandom_range(0, 31)), rnd128(), rnd128(),
                 (o <= 4'd8) ? names[o] : "R12 stream");
        end
        send(0, 4'd0, 5'd0, 5'd0, 5'd0, '0, '0, "R13 final idle");

        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule